// File: doc/BRIEF.md
# JTAG-Controlled Flash Access Arbiter

This block decides who drives a shared flash bus: an external host, or an in-system programming (ISP) engine steered by a JTAG test access port. The block does not contain the TAP state machine. It watches the TAP's Test-Logic-Reset and Update-IR state flags and the current instruction register value. From these it keeps a "hold" flag in the TCK domain. While the flag is set, an open-drain init line pulls low and keeps a downstream FPGA in configuration reset.

The hold flag is carried into the flash clock domain through a two-flop synchronizer. There an ownership state machine takes the bus away from the host. If the host is in the middle of an access, the machine first raises an abort and waits for the host to acknowledge it. Only then does it grant the ISP engine. A release instruction clears the flag, lets the init line float high so the FPGA reconfigures, and hands the bus back to the host. The hold instruction is optional. Without it, the ISP engine can still take an idle bus by request, but nothing then stops the host from contending for it.

Top module: `jtag_flash_arbiter`

## Requirements
- R1: After reset, the init pull-down enable is 0, the host is granted, the ISP engine is not granted, no abort is raised, and the flash bus carries the host's address.
- R2: An Update-IR with the instruction value HOLD_CODE (default 4'h8) sets the init pull-down enable at that TCK rising edge. Loading HOLD_CODE without Update-IR has no effect on it.
- R3: Once set, the init pull-down enable stays set through Update-IR of any other instruction. It is cleared only by an Update-IR with RELEASE_CODE (default 4'h9).
- R4: Test-Logic-Reset clears the hold flag, drops the init pull-down enable and returns the bus to the host.
- R5: When the hold flag reaches the flash domain while the host is not busy, the host loses its grant and the ISP engine is granted without any abort.
- R6: When the hold flag arrives while the host is busy, the abort output rises and the host grant falls. The ISP engine stays ungranted until the host asserts its abort acknowledge. The ISP grant follows one clock later, and the abort falls at the same time.
- R7: While the ISP engine is granted, the host grant is 0 and the flash bus carries the ISP engine's signals whatever the host drives.
- R8: The release instruction returns ownership to the host: the ISP grant drops and the host grant rises.
- R9: The host and the ISP engine are never granted in the same clock. The flash bus drive enable is 1 exactly when one of them is granted.
- R10: Without the hold flag, an ISP request takes the bus only when the host neither requests nor is busy. A host request is then held off until the ISP request drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | JTAG test clock |
| trst_n | input | 1 | Asynchronous active-low TAP reset |
| tap_tlr | input | 1 | TAP is in Test-Logic-Reset |
| tap_update_ir | input | 1 | TAP is in Update-IR |
| ir_value | input | IR_W | Current instruction register contents |
| clk | input | 1 | Flash bus clock |
| rst_n | input | 1 | Asynchronous active-low flash-domain reset |
| host_req | input | 1 | Host wants the flash bus |
| host_busy | input | 1 | Host has an access in progress |
| host_abort_ack | input | 1 | Host has terminated its access |
| host_addr | input | AW | Host flash address |
| host_wdata | input | DW | Host write data |
| host_we | input | 1 | Host write enable |
| host_oe | input | 1 | Host output enable |
| isp_req | input | 1 | ISP engine wants the bus without a hold |
| isp_addr | input | AW | ISP flash address |
| isp_wdata | input | DW | ISP write data |
| isp_we | input | 1 | ISP write enable |
| isp_oe | input | 1 | ISP output enable |
| host_grant | output | 1 | Host may drive the flash bus |
| isp_grant | output | 1 | ISP engine may drive the flash bus |
| host_abort | output | 1 | Host must terminate its access |
| init_pull_low | output | 1 | Open-drain enable: 1 pulls the init line low, 0 leaves it floating |
| fl_drive_en | output | 1 | Flash bus output enable |
| fl_addr | output | AW | Flash address |
| fl_wdata | output | DW | Flash write data |
| fl_we | output | 1 | Flash write enable |
| fl_oe | output | 1 | Flash output enable |

## Verification
The assertions assume the TAP never flags Update-IR and Test-Logic-Reset in the same TCK cycle. They also assume the host raises its abort acknowledge only while an abort is pending. The stimulus changes TAP flags only on TCK falling edges, and it raises the acknowledge only after it has seen the abort at the ports. The bench leaves several flash clocks between a TCK update and the next check, so the two-flop crossing has settled before any sample is taken.

// File: rtl/jfa_pkg.sv
package jfa_pkg;
  typedef enum logic [1:0] {
    OWN_HOST  = 2'd0,
    OWN_ABORT = 2'd1,
    OWN_HOLD  = 2'd2,
    OWN_OPEN  = 2'd3
  } own_state_t;

  function automatic logic isp_owns(input own_state_t s);
    return (s == OWN_HOLD) || (s == OWN_OPEN);
  endfunction

  function automatic logic host_owns(input own_state_t s);
    return s == OWN_HOST;
  endfunction
endpackage

// File: rtl/jfa_tck_ctrl.sv
module jfa_tck_ctrl #(
  parameter int IR_W = 4,
  parameter logic [IR_W-1:0] HOLD_CODE = 4'h8,
  parameter logic [IR_W-1:0] RELEASE_CODE = 4'h9
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tap_tlr,
  input  logic            tap_update_ir,
  input  logic [IR_W-1:0] ir_value,
  output logic            hold_tck,
  output logic            hold_hit,
  output logic            release_hit
);
  function automatic logic upd_match(input logic upd, input logic [IR_W-1:0] ir,
                                     input logic [IR_W-1:0] code);
    return upd && (ir == code);
  endfunction

  assign hold_hit    = upd_match(tap_update_ir, ir_value, HOLD_CODE);
  assign release_hit = upd_match(tap_update_ir, ir_value, RELEASE_CODE);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)          hold_tck <= 1'b0;
    else if (tap_tlr)     hold_tck <= 1'b0;
    else if (hold_hit)    hold_tck <= 1'b1;
    else if (release_hit) hold_tck <= 1'b0;
  end
endmodule

// File: rtl/jfa_sync.sv
module jfa_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/jfa_own_fsm.sv
module jfa_own_fsm
  import jfa_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold_s,
  input  logic       host_req,
  input  logic       host_busy,
  input  logic       host_abort_ack,
  input  logic       isp_req,
  output own_state_t state,
  output logic       host_grant,
  output logic       isp_grant,
  output logic       host_abort
);
  own_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      OWN_HOST: begin
        if (hold_s)                                  nxt = host_busy ? OWN_ABORT : OWN_HOLD;
        else if (isp_req && !host_req && !host_busy) nxt = OWN_OPEN;
      end
      OWN_ABORT: if (host_abort_ack) nxt = hold_s ? OWN_HOLD : OWN_HOST;
      OWN_HOLD:  if (!hold_s)        nxt = OWN_HOST;
      OWN_OPEN: begin
        if (hold_s)        nxt = OWN_HOLD;
        else if (!isp_req) nxt = OWN_HOST;
      end
      default: nxt = OWN_HOST;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= OWN_HOST;
    else        state <= nxt;
  end

  assign host_grant = host_owns(state);
  assign isp_grant  = isp_owns(state);
  assign host_abort = (state == OWN_ABORT);
endmodule

// File: rtl/jfa_bus_mux.sv
module jfa_bus_mux #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          sel_host,
  input  logic          sel_isp,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_we,
  input  logic          host_oe,
  input  logic [AW-1:0] isp_addr,
  input  logic [DW-1:0] isp_wdata,
  input  logic          isp_we,
  input  logic          isp_oe,
  output logic          fl_drive_en,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_wdata,
  output logic          fl_we,
  output logic          fl_oe
);
  always_comb begin
    fl_drive_en = sel_host ^ sel_isp;
    fl_addr = '0; fl_wdata = '0; fl_we = 1'b0; fl_oe = 1'b0;
    if (sel_isp) begin
      fl_addr = isp_addr; fl_wdata = isp_wdata; fl_we = isp_we; fl_oe = isp_oe;
    end else if (sel_host) begin
      fl_addr = host_addr; fl_wdata = host_wdata; fl_we = host_we; fl_oe = host_oe;
    end
  end
endmodule

// File: rtl/jtag_flash_arbiter.sv
module jtag_flash_arbiter
  import jfa_pkg::*;
#(
  parameter int IR_W = 4,
  parameter logic [IR_W-1:0] HOLD_CODE = 4'h8,
  parameter logic [IR_W-1:0] RELEASE_CODE = 4'h9,
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tap_tlr,
  input  logic            tap_update_ir,
  input  logic [IR_W-1:0] ir_value,
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_req,
  input  logic            host_busy,
  input  logic            host_abort_ack,
  input  logic [AW-1:0]   host_addr,
  input  logic [DW-1:0]   host_wdata,
  input  logic            host_we,
  input  logic            host_oe,
  input  logic            isp_req,
  input  logic [AW-1:0]   isp_addr,
  input  logic [DW-1:0]   isp_wdata,
  input  logic            isp_we,
  input  logic            isp_oe,
  output logic            host_grant,
  output logic            isp_grant,
  output logic            host_abort,
  output logic            init_pull_low,
  output logic            fl_drive_en,
  output logic [AW-1:0]   fl_addr,
  output logic [DW-1:0]   fl_wdata,
  output logic            fl_we,
  output logic            fl_oe
);
  logic       hold_tck;
  logic       hold_hit;
  logic       release_hit;
  logic       hold_s;
  own_state_t own_state;

  jfa_tck_ctrl #(.IR_W(IR_W), .HOLD_CODE(HOLD_CODE), .RELEASE_CODE(RELEASE_CODE)) tck_i (
    .tck(tck), .trst_n(trst_n), .tap_tlr(tap_tlr), .tap_update_ir(tap_update_ir),
    .ir_value(ir_value), .hold_tck(hold_tck), .hold_hit(hold_hit),
    .release_hit(release_hit)
  );

  assign init_pull_low = hold_tck;

  jfa_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(hold_tck), .q(hold_s)
  );

  jfa_own_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .hold_s(hold_s), .host_req(host_req),
    .host_busy(host_busy), .host_abort_ack(host_abort_ack), .isp_req(isp_req),
    .state(own_state), .host_grant(host_grant), .isp_grant(isp_grant),
    .host_abort(host_abort)
  );

  jfa_bus_mux #(.AW(AW), .DW(DW)) mux_i (
    .sel_host(host_grant), .sel_isp(isp_grant),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_we(host_we), .host_oe(host_oe),
    .isp_addr(isp_addr), .isp_wdata(isp_wdata), .isp_we(isp_we), .isp_oe(isp_oe),
    .fl_drive_en(fl_drive_en), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_we(fl_we), .fl_oe(fl_oe)
  );
endmodule

// File: rtl/jfa_checker.sv
module jfa_checker #(
  parameter int IR_W = 4,
  parameter logic [IR_W-1:0] HOLD_CODE = 4'h8,
  parameter logic [IR_W-1:0] RELEASE_CODE = 4'h9,
  parameter int AW = 20
) (
  input logic            tck,
  input logic            trst_n,
  input logic            tap_tlr,
  input logic            tap_update_ir,
  input logic [IR_W-1:0] ir_value,
  input logic            clk,
  input logic            rst_n,
  input logic            hold_s,
  input logic            host_grant,
  input logic            isp_grant,
  input logic            host_abort,
  input logic            host_abort_ack,
  input logic            init_pull_low,
  input logic            fl_drive_en,
  input logic [AW-1:0]   fl_addr,
  input logic [AW-1:0]   isp_addr
);
  a_r9_grants_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_grant && isp_grant));

  a_r9_drive_matches_grant: assert property (@(posedge clk) disable iff (!rst_n)
    fl_drive_en == (host_grant || isp_grant));

  a_r7_isp_owns_bus: assert property (@(posedge clk) disable iff (!rst_n)
    isp_grant |-> (!host_grant && fl_addr == isp_addr));

  a_r6_abort_held: assert property (@(posedge clk) disable iff (!rst_n)
    (host_abort && !host_abort_ack) |=> host_abort);

  a_r6_grant_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(isp_grant) && $past(host_abort)) |-> $past(host_abort_ack));

  a_r5_hold_takes_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_s && isp_grant) |=> isp_grant);

  a_r2_hold_sets_init: assert property (@(posedge tck) disable iff (!trst_n)
    (tap_update_ir && ir_value == HOLD_CODE && !tap_tlr) |=> init_pull_low);

  a_r4_tlr_releases: assert property (@(posedge tck) disable iff (!trst_n)
    tap_tlr |=> !init_pull_low);

  a_r3_release_only_on_code: assert property (@(posedge tck) disable iff (!trst_n)
    $fell(init_pull_low) |-> ($past(tap_tlr) ||
      ($past(tap_update_ir) && $past(ir_value) == RELEASE_CODE)));
endmodule

bind jtag_flash_arbiter jfa_checker #(
  .IR_W(IR_W), .HOLD_CODE(HOLD_CODE), .RELEASE_CODE(RELEASE_CODE), .AW(AW)
) chk_i (
  .tck(tck), .trst_n(trst_n), .tap_tlr(tap_tlr), .tap_update_ir(tap_update_ir),
  .ir_value(ir_value), .clk(clk), .rst_n(rst_n), .hold_s(hold_s),
  .host_grant(host_grant), .isp_grant(isp_grant), .host_abort(host_abort),
  .host_abort_ack(host_abort_ack), .init_pull_low(init_pull_low),
  .fl_drive_en(fl_drive_en), .fl_addr(fl_addr), .isp_addr(isp_addr)
);

// File: tb/jtag_flash_arbiter_tb_top.sv
module jtag_flash_arbiter_tb_top;
  localparam int IR_W = 4;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam logic [IR_W-1:0] HOLD = 4'h8;
  localparam logic [IR_W-1:0] REL  = 4'h9;

  logic clk = 0, tck = 0;
  always #10 clk = ~clk;
  always #50 tck = ~tck;

  logic trst_n = 0, rst_n = 0, tap_tlr = 0, tap_update_ir = 0;
  logic [IR_W-1:0] ir_value = '0;
  logic host_req = 0, host_busy = 0, host_abort_ack = 0, host_we = 0, host_oe = 0;
  logic isp_req = 0, isp_we = 0, isp_oe = 0;
  logic [AW-1:0] host_addr = 20'h11111, isp_addr = 20'h22222;
  logic [DW-1:0] host_wdata = 16'hAAAA, isp_wdata = 16'h5555;
  logic host_grant, isp_grant, host_abort, init_pull_low, fl_drive_en, fl_we, fl_oe;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_wdata;

  jtag_flash_arbiter dut_i (
    .tck(tck), .trst_n(trst_n), .tap_tlr(tap_tlr), .tap_update_ir(tap_update_ir),
    .ir_value(ir_value), .clk(clk), .rst_n(rst_n), .host_req(host_req),
    .host_busy(host_busy), .host_abort_ack(host_abort_ack), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_we(host_we), .host_oe(host_oe), .isp_req(isp_req),
    .isp_addr(isp_addr), .isp_wdata(isp_wdata), .isp_we(isp_we), .isp_oe(isp_oe),
    .host_grant(host_grant), .isp_grant(isp_grant), .host_abort(host_abort),
    .init_pull_low(init_pull_low), .fl_drive_en(fl_drive_en), .fl_addr(fl_addr),
    .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_oe(fl_oe)
  );

  typedef struct {
    string         req;
    logic          pull;
    logic          hg;
    logic          ig;
    logic          ab;
    logic [AW-1:0] addr;
  } exp_t;

  exp_t sb_q[$];
  int checks = 0, failures = 0;
  bit done = 0, live = 0;

  task automatic expect_now(string req, logic pull, logic hg, logic ig, logic ab);
    exp_t e;
    e.req = req; e.pull = pull; e.hg = hg; e.ig = ig; e.ab = ab;
    e.addr = ig ? isp_addr : (hg ? host_addr : '0);
    sb_q.push_back(e);
    wait (sb_q.size() == 0);
    @(posedge clk);
  endtask

  // monitor: pops expected items and compares away from the active edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if ({init_pull_low, host_grant, isp_grant, host_abort, fl_addr} !==
          {e.pull, e.hg, e.ig, e.ab, e.addr}) begin
        failures++;
        $display("FAIL %s: pull/hg/ig/abort/addr actual %b%b%b%b %h expected %b%b%b%b %h",
                 e.req, init_pull_low, host_grant, isp_grant, host_abort, fl_addr,
                 e.pull, e.hg, e.ig, e.ab, e.addr);
      end
    end
    if (live && host_grant && isp_grant) begin
      failures++;
      $display("FAIL R9: both grants actual 11 expected not both");
    end
  end

  task automatic tap_update(logic [IR_W-1:0] code);
    @(negedge tck); ir_value = code; tap_update_ir = 1;
    @(negedge tck); tap_update_ir = 0;
    repeat (6) @(posedge clk);
  endtask

  task automatic tap_reset();
    @(negedge tck); tap_tlr = 1;
    @(negedge tck); tap_tlr = 0;
    repeat (6) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run hung actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    trst_n = 1; rst_n = 1;
    repeat (3) @(posedge clk);
    live = 1;
    expect_now("R1 reset state", 0, 1, 0, 0);

    // R2: HOLD loaded but no Update-IR
    @(negedge tck); ir_value = HOLD;
    repeat (3) @(negedge tck);
    repeat (6) @(posedge clk);
    expect_now("R2 load without update", 0, 1, 0, 0);

    // R2, R5: hold with host idle
    tap_update(HOLD);
    expect_now("R2 R5 hold idle host", 1, 0, 1, 0);
    // R7: host drive changes ignored
    host_addr = 20'h33333; host_req = 1;
    repeat (2) @(posedge clk);
    expect_now("R7 isp owns bus", 1, 0, 1, 0);
    host_req = 0;
    // R3: other instruction keeps hold
    tap_update(4'h3);
    expect_now("R3 other update keeps hold", 1, 0, 1, 0);
    // R3, R8: release
    tap_update(REL);
    expect_now("R3 R8 release", 0, 1, 0, 0);

    // R6: hold with busy host
    host_busy = 1;
    tap_update(HOLD);
    expect_now("R6 abort raised", 1, 0, 0, 1);
    repeat (10) @(posedge clk);
    expect_now("R6 no grant before ack", 1, 0, 0, 1);
    @(negedge clk); host_abort_ack = 1; host_busy = 0;
    @(negedge clk); host_abort_ack = 0;
    expect_now("R6 grant after ack", 1, 0, 1, 0);

    // R4: TLR releases
    tap_reset();
    expect_now("R4 tlr releases", 0, 1, 0, 0);

    // R10: ISP without hold
    @(negedge clk); isp_req = 1;
    repeat (3) @(posedge clk);
    expect_now("R10 isp open grant", 0, 0, 1, 0);
    @(negedge clk); host_req = 1;
    repeat (3) @(posedge clk);
    expect_now("R10 host held off", 0, 0, 1, 0);
    @(negedge clk); isp_req = 0;
    repeat (3) @(posedge clk);
    expect_now("R10 host regains", 0, 1, 0, 0);
    @(negedge clk); isp_req = 1;
    repeat (4) @(posedge clk);
    expect_now("R10 isp refused while host requests", 0, 1, 0, 0);
    @(negedge clk); isp_req = 0; host_req = 0;
    repeat (2) @(posedge clk);

    // R9: drive enable tracks single grant
    checks++;
    if (fl_drive_en !== 1'b1) begin
      failures++;
      $display("FAIL R9: drive_en actual %b expected 1", fl_drive_en);
    end
    done = 1;
    finish_run();
  end
endmodule